// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a simple on-chip request port and an external asynchronous static RAM of 65,536 bytes. It takes one read or write at a time (16-bit address, 8-bit write data) through a valid/ready handshake. It then plays out the memory's control strobes as a series of phases, each a whole number of clock cycles long. The strobes are a low-true chip select, a high-true chip select, a low-true write strobe and a low-true output enable. Read data comes back on a one-cycle response pulse.

Phase lengths are derived at elaboration time from the clock period and the memory's timing minimums, each rounded up to whole cycles. The data bus is split into output value, output enable and input value so that the pad ring can build the tristate buffer. The sequencer never drives the bus while the memory could be driving it. It also keeps the write strobe high whenever the address moves. With the default 5 ns clock, a read keeps the strobes active for 4 cycles. A write holds its strobe low for 3 cycles, framed by one setup cycle and one hold cycle.

Top module: `xsram_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, the memory is deselected (`mem_ce_n`=1, `mem_ce`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_valid`=0, and `req_ready`=1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Its address, data and direction (`req_write`=1 for write) are captured at that edge. `req_ready` stays 0 until the sequence ends and returns to 1 five cycles after acceptance for both reads and writes at default timing.
- R3: A read puts the captured address on `mem_addr` with `mem_ce_n`=0, `mem_ce`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 from the cycle after acceptance. These are held for ceil(max(20 ns access, 20 ns cycle)/period) cycles, which is 4 at 5 ns.
- R4: Read data is sampled from `mem_dq_i` at the end of the last access cycle. It appears on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle, the fifth cycle after acceptance at defaults.
- R5: A write spends one setup cycle with the chip selected, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=1 and `mem_dq_o` set to the captured data. It then holds `mem_we_n`=0 for ceil(12 ns/period) cycles (3 at 5 ns), then spends one hold cycle with the chip still selected, `mem_we_n`=1 and the data still driven. The chip is selected for 5 cycles in total, and `mem_we_n` is only 0 while the chip is selected.
- R6: `mem_dq_oe` and a low `mem_oe_n` never occur in the same cycle.
- R7: After `mem_oe_n` returns high, at least two full cycles pass before `mem_dq_oe` rises.
- R8: `mem_addr` changes only at an edge where `mem_we_n` is 1 both before and after.
- R9: A write produces no `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data to pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | DATA_W | Data from pad |

## Verification
The bench pairs the sequencer with a memory model. In that model, read data turns valid only after the strobes have been active for the full access time, and writes land on the rising write strobe, so phases that are too short show up as wrong data. Directed cases cover the lowest and highest addresses, reads of never-written locations, and a read followed at once by a write and another read, which exposes missing turnaround. Random mixes of reads and writes over a small hot set of addresses, so that reads hit earlier writes, with random idle gaps and back-to-back requests, separate correct data ordering from stale or misdirected stores. Monitors check strobe overlap, turnaround length and address moves on every cycle.

// File: rtl/xsram_pkg.sv
// Shared types and elaboration-time helpers for the static RAM sequencer.
// Assumes all timing values are given in picoseconds.
package xsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } xs_state_e;

    typedef struct packed {
        logic ce_n;
        logic ce;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } xs_pins_t;

    localparam xs_pins_t PINS_QUIET = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1,
                                        oe_n: 1'b1, dq_oe: 1'b0};

    // Round a time up to whole clock cycles.
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xsram_timer.sv
// Phase timer: a loadable down counter that reports expiry at zero.
// Assumes the controller loads it on entry to every timed phase.
module xsram_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Count down toward zero; a load overrides the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0)); // R3

endmodule

// File: rtl/xsram_strobes.sv
// Strobe register: decodes the next phase into memory control pins and
// registers them so the pins are glitch free and change on one edge.
// Assumes the phase encoding from xsram_pkg.
module xsram_strobes
    import xsram_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  xs_state_e nxt_state,
    output xs_pins_t  pins
);
    xs_pins_t pins_d;

    // Map each phase to its pin levels.
    always_comb begin
        pins_d = PINS_QUIET;
        unique case (nxt_state)
            ST_RD_ACC: begin
                pins_d.ce_n = 1'b0;
                pins_d.ce   = 1'b1;
                pins_d.oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                pins_d.ce_n  = 1'b0;
                pins_d.ce    = 1'b1;
                pins_d.dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                pins_d.ce_n  = 1'b0;
                pins_d.ce    = 1'b1;
                pins_d.we_n  = 1'b0;
                pins_d.dq_oe = 1'b1;
            end
            default: pins_d = PINS_QUIET;
        endcase
    end

    // Register the pins; reset leaves the memory deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pins <= PINS_QUIET;
        else
            pins <= pins_d;
    end

    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !pins.we_n |-> (!pins.ce_n && pins.ce)); // R5

endmodule

// File: rtl/xsram_datapath.sv
// Address, write-data and read-data registers. The address and write data
// are loaded only when a request is accepted; read data is captured on
// the controller's capture strobe and flagged for one cycle.
module xsram_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] rdata,
    output logic              rsp_valid
);
    // Hold the request fields for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_o     <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            dq_o     <= req_wdata;
        end
    end

    // Capture read data and raise a one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (capture)
                rdata <= dq_i;
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4

endmodule

// File: rtl/xsram_ctrl.sv
// Static RAM access sequencer (top). Accepts one request at a time and
// steps through timed phases: read access then a bus turnaround, or
// write setup, write pulse and write hold. Phase lengths come from the
// clock period and timing minimums. Assumes the pad ring builds the
// tristate driver from mem_dq_o / mem_dq_oe and returns mem_dq_i.
module xsram_ctrl
    import xsram_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int CLK_PERIOD_PS = 5000,
    parameter int T_CYCLE_PS    = 20000,
    parameter int T_ACCESS_PS   = 20000,
    parameter int T_WPULSE_PS   = 12000,
    parameter int T_HIZ_PS      = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // Phase lengths in cycles, each minimum rounded up.
    localparam int unsigned CYC_MIN  = ps_to_cycles(T_CYCLE_PS, CLK_PERIOD_PS);
    localparam int unsigned RD_CYC   = max_u(1, max_u(ps_to_cycles(T_ACCESS_PS, CLK_PERIOD_PS), CYC_MIN));
    localparam int unsigned WP_CYC   = max_u(1, max_u(ps_to_cycles(T_WPULSE_PS, CLK_PERIOD_PS),
                                                    (CYC_MIN > 2) ? CYC_MIN - 2 : 1));
    localparam int unsigned TURN_CYC = max_u(1, ps_to_cycles(T_HIZ_PS, CLK_PERIOD_PS));
    localparam int unsigned MAX_CYC  = max_u(RD_CYC, max_u(WP_CYC, TURN_CYC));
    localparam int          CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    xs_state_e        state, nxt;
    xs_pins_t         pins;
    logic             accept, capture, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic [1:0]       oe_quiet;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state == ST_RD_ACC) && tmr_done;

    // Next-phase selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) nxt = req_write ? ST_WR_SETUP : ST_RD_ACC;
            ST_RD_ACC:   if (tmr_done) nxt = ST_RD_TURN;
            ST_RD_TURN:  if (tmr_done) nxt = ST_IDLE;
            ST_WR_SETUP: nxt = ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_done) nxt = ST_WR_HOLD;
            ST_WR_HOLD:  nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Timer load on entry to a timed phase.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (nxt != state) begin
            unique case (nxt)
                ST_RD_ACC:   begin tmr_load = 1'b1; tmr_val = CNT_W'(RD_CYC - 1);   end
                ST_RD_TURN:  begin tmr_load = 1'b1; tmr_val = CNT_W'(TURN_CYC - 1); end
                ST_WR_PULSE: begin tmr_load = 1'b1; tmr_val = CNT_W'(WP_CYC - 1);   end
                default:     begin tmr_load = 1'b0; tmr_val = '0;                   end
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    xsram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    xsram_strobes u_strobes (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt),
        .pins      (pins)
    );

    xsram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .dq_i      (mem_dq_i),
        .mem_addr  (mem_addr),
        .dq_o      (mem_dq_o),
        .rdata     (rsp_rdata),
        .rsp_valid (rsp_valid)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_ce    = pins.ce;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.dq_oe;

    // Cycles since output enable was last low, saturating; guards turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_quiet <= 2'd3;
        else if (!mem_oe_n)
            oe_quiet <= 2'd0;
        else if (oe_quiet != 2'd3)
            oe_quiet <= oe_quiet + 2'd1;
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (req_ready && mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_NO_DRIVE_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n)); // R6
    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_quiet >= 2'd2)); // R7
    AST_ADDR_MOVES_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n))); // R8
    AST_NO_WRITE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(state == ST_RD_ACC)); // R9

endmodule

// File: tb/xsram_ctrl_bench.sv
// Bench: sequencer plus a behavioural memory whose read data is valid only
// after four active cycles and whose writes land on the rising write strobe.
module xsram_ctrl_bench;
    localparam int RD_EXP   = 4;  // R3 active read cycles
    localparam int WP_EXP   = 3;  // R5 write strobe cycles
    localparam int WSEL_EXP = 5;  // R5 selected cycles for a write
    localparam int DONE_EXP = 5;  // R2 cycles to ready again
    localparam int RSP_EXP  = 4;  // R4 sample index of response

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_o, mem_dq_i;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int cycles = 0;

    logic [7:0] sram_mem [logic [15:0]];
    logic [7:0] ref_mem  [logic [15:0]];
    int rd_age = 0;

    always #2.5 clk = ~clk;

    xsram_ctrl u_xsram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [7:0] fill_pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : fill_pat(a);
    endfunction

    function automatic logic [7:0] dev_read(input logic [15:0] a);
        return sram_mem.exists(a) ? sram_mem[a] : fill_pat(a);
    endfunction

    // Memory model: write on the rising write strobe while selected.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_ce)
            sram_mem[mem_addr] = mem_dq_oe ? mem_dq_o : 8'hxx;
    end

    // Memory model: count cycles the read strobes have been active.
    always @(negedge clk) begin
        if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n)
            rd_age <= rd_age + 1;
        else
            rd_age <= 0;
    end

    assign mem_dq_i = (rd_age >= RD_EXP) ? dev_read(mem_addr) : ~dev_read(mem_addr);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bus monitors for R6, R7, R8.
    int oe_quiet = 3;
    logic prev_dq_oe = 1'b0, prev_we_n = 1'b1;
    logic [15:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_dq_oe)
                check(mem_oe_n, "R6 drive while output enabled", mem_oe_n, 1);
            if (mem_dq_oe && !prev_dq_oe)
                check(oe_quiet >= 2, "R7 turnaround cycles", oe_quiet, 2);
            if (mem_addr != prev_addr)
                check(mem_we_n && prev_we_n, "R8 address moved with write strobe low",
                      {mem_we_n, prev_we_n}, 3);
        end
        oe_quiet   = !mem_oe_n ? 0 : ((oe_quiet < 3) ? oe_quiet + 1 : 3);
        prev_dq_oe = mem_dq_oe;
        prev_we_n  = mem_we_n;
        prev_addr  = mem_addr;
    end

    // One request and its full observation window.
    task automatic do_txn(input bit wr, input logic [15:0] a, input logic [7:0] d);
        int we_low = 0, oe_low = 0, sel = 0, rsp_cnt = 0, rsp_idx = -1, rdy_idx = -1;
        logic [7:0] got = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
        check(!req_ready, "R2 ready low after accept", req_ready, 0);
        if (wr)
            check(!mem_ce_n && mem_ce && mem_we_n && mem_oe_n && mem_dq_oe &&
                  mem_dq_o == d && mem_addr == a, "R5 write setup pins",
                  {mem_dq_o, mem_addr}, {d, a});
        else
            check(!mem_ce_n && mem_ce && mem_we_n && !mem_oe_n && !mem_dq_oe &&
                  mem_addr == a, "R3 read access pins", mem_addr, a);
        for (int idx = 0; idx < 20; idx++) begin
            if (req_ready) begin rdy_idx = idx; break; end
            if (!mem_we_n) we_low++;
            if (!mem_oe_n) oe_low++;
            if (!mem_ce_n && mem_ce) sel++;
            if (rsp_valid) begin rsp_cnt++; rsp_idx = idx; got = rsp_rdata; end
            @(negedge clk);
        end
        check(rdy_idx == DONE_EXP, "R2 ready return cycle", rdy_idx, DONE_EXP);
        if (wr) begin
            check(we_low == WP_EXP, "R5 write strobe width", we_low, WP_EXP);
            check(sel == WSEL_EXP, "R5 write select cycles", sel, WSEL_EXP);
            check(rsp_cnt == 0, "R9 response after write", rsp_cnt, 0);
            ref_mem[a] = d;
        end else begin
            check(oe_low == RD_EXP && sel == RD_EXP, "R3 read active cycles", oe_low, RD_EXP);
            check(rsp_cnt == 1 && rsp_idx == RSP_EXP, "R4 response timing", rsp_idx, RSP_EXP);
            check(got == exp_read(a), "R4 read data", got, exp_read(a));
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
              "R1 pins during reset", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_ce_n && !mem_ce && mem_oe_n && !mem_dq_oe,
              "R1 idle after reset", req_ready, 1);

        // Directed corners.
        do_txn(1'b0, 16'h1234, 8'h00);      // unwritten location
        do_txn(1'b1, 16'h0000, 8'h00);
        do_txn(1'b1, 16'hFFFF, 8'hFF);
        do_txn(1'b0, 16'h0000, 8'h00);
        do_txn(1'b0, 16'hFFFF, 8'h00);
        do_txn(1'b1, 16'h00A5, 8'h5A);      // read -> write -> read turnaround
        do_txn(1'b0, 16'h00A5, 8'h00);
        do_txn(1'b1, 16'h00A5, 8'hC3);
        do_txn(1'b0, 16'h00A5, 8'h00);

        // Random mix over a hot set and the full range.
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            bit wr;
            a  = ($urandom_range(0, 3) == 0) ? 16'($urandom) : {12'h0, 4'($urandom)};
            d  = 8'($urandom);
            wr = 1'($urandom);
            repeat ($urandom_range(0, 2)) @(negedge clk);
            do_txn(wr, a, d);
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule